// File: doc/BRIEF.md
# Codec Register Access Controller

This block sits between host software and the framing logic of an AC97-style serial link. It lets software read and write registers inside the primary audio codec through one 32-bit command/status word. Software writes a command word to start a transaction. It then polls the same word until the busy flag drops. After a read it also waits for the data-valid flag before it takes the returned value from the low half.

Each accepted command goes to the link framer as a held request: read/write flag, register index and write data. The framer answers with a one-cycle acknowledge, which carries the read data for a read. A bounded wait guards against a framer that never answers, so every transaction ends well inside the host's 1 ms polling budget. A command that arrives while a transaction is in flight is dropped, and a sticky flag records the collision.

Top module: `codec_cmd_ctrl`

## Requirements
- R1: After reset the status word `rd_data` reads all zeros and `lnk_req` is low.
- R2: A write of `wr_data` with bit 24 (launch/valid) set while bit 25 (busy) reads 0 sets busy and `lnk_req` on the next cycle. It presents `lnk_rd` = bit 23, `lnk_idx` = bits 22:16 and `lnk_wdata` = bits 15:0, and holds them until the transaction ends.
- R3: On `lnk_ack` for a write transaction, busy clears on the next cycle. The data-valid bit 24 keeps its value, and bits 15:0 hold the written data.
- R4: Launching a read clears bit 24 on the next cycle. On that read's `lnk_ack`, `lnk_rdata` is latched into bits 15:0, bit 24 is set and busy clears, all on the next cycle.
- R5: A command written while busy is ignored: the link request fields and the transaction's outcome are unchanged. The sticky overrun bit 26 is set on the next cycle.
- R6: The overrun bit stays set until a command is accepted with bit 26 set in the written word. An accepted command with bit 26 clear leaves it set.
- R7: A write with bit 24 clear while idle starts nothing: busy, `lnk_req` and the whole status word are unchanged.
- R8: If no acknowledge arrives within TMO_CYCLES busy cycles, the transaction ends. Busy clears, the expired bit 27 is set, bit 24 stays as the launch left it, and bits 15:0 keep the command's data. The next accepted command clears bit 27.
- R9: An acknowledge while idle changes nothing in the status word.
- R10: Busy never stays high for more than TMO_CYCLES consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the command word |
| wr_data | input | 32 | Command word written by the host |
| rd_data | output | 32 | Status word: data, index, read flag, valid, busy, overrun, expired |
| lnk_req | output | 1 | Transaction request to the link framer |
| lnk_rd | output | 1 | Request is a read |
| lnk_idx | output | 7 | Codec register index |
| lnk_wdata | output | 16 | Data for a write transaction |
| lnk_ack | input | 1 | One-cycle completion from the link framer |
| lnk_rdata | input | 16 | Read data, valid with `lnk_ack` |

## Verification
The bench builds the block with TMO_CYCLES set to 24 instead of the default 2000. This makes the expiry path, and the exact cycle on which busy drops after an unanswered request, reachable in a short run. The index and data widths stay at their defaults, so the bench can compare every status bit position against the encodings stated in the requirements. The framer model answers with latencies from zero to five cycles, which covers an acknowledge on the very first request cycle.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  typedef enum logic [0:0] {
    LS_IDLE = 1'b0,
    LS_WAIT = 1'b1
  } link_state_e;

  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/ccr_accept.sv
module ccr_accept (
  input  logic wr_en,
  input  logic cmd_vld,
  input  logic cmd_clr_ovr,
  input  logic busy,
  output logic launch,
  output logic collide,
  output logic clr_ovr
);

  always_comb begin
    launch  = wr_en && !busy && cmd_vld;
    collide = wr_en && busy;
    clr_ovr = launch && cmd_clr_ovr;
  end

endmodule

// File: rtl/ccr_link_fsm.sv
module ccr_link_fsm #(
  parameter int unsigned IDX_W      = 7,
  parameter int unsigned DAT_W      = 16,
  parameter int unsigned TMO_CYCLES = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             cmd_rd,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [DAT_W-1:0] cmd_wdata,
  input  logic             ack,
  output logic             busy,
  output logic             req_rd,
  output logic [IDX_W-1:0] req_idx,
  output logic [DAT_W-1:0] req_wdata,
  output logic             done_ok,
  output logic             expire
);
  import ccr_pkg::*;

  localparam int unsigned CW = cnt_width(TMO_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  link_state_e     state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            rd_q;
  logic [IDX_W-1:0] idx_q;
  logic [DAT_W-1:0] wdata_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_ok = 1'b0;
    expire  = 1'b0;
    case (state_q)
      LS_IDLE: begin
        if (launch) begin
          state_d = LS_WAIT;
          cnt_d   = '0;
        end
      end
      LS_WAIT: begin
        if (ack) begin
          done_ok = 1'b1;
          state_d = LS_IDLE;
        end else if (cnt_q == LAST) begin
          expire  = 1'b1;
          state_d = LS_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // command fields, loaded only on launch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      idx_q   <= '0;
      wdata_q <= '0;
    end else if (launch) begin
      rd_q    <= cmd_rd;
      idx_q   <= cmd_idx;
      wdata_q <= cmd_wdata;
    end
  end

  always_comb begin
    busy      = (state_q == LS_WAIT);
    req_rd    = rd_q;
    req_idx   = idx_q;
    req_wdata = wdata_q;
  end

endmodule

// File: rtl/ccr_status.sv
module ccr_status #(
  parameter int unsigned DAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             cmd_rd,
  input  logic [DAT_W-1:0] cmd_data,
  input  logic             collide,
  input  logic             clr_ovr,
  input  logic             done_ok,
  input  logic             done_rd,
  input  logic [DAT_W-1:0] ack_data,
  input  logic             expire,
  output logic             valid,
  output logic [DAT_W-1:0] data,
  output logic             overrun,
  output logic             expired
);

  logic             valid_q, valid_d;
  logic [DAT_W-1:0] data_q, data_d;
  logic             ovr_q, ovr_d;
  logic             exp_q, exp_d;

  always_comb begin
    valid_d = valid_q;
    data_d  = data_q;
    ovr_d   = ovr_q;
    exp_d   = exp_q;

    if (launch) begin
      data_d = cmd_data;
      if (cmd_rd) valid_d = 1'b0;
    end else if (done_ok && done_rd) begin
      data_d  = ack_data;
      valid_d = 1'b1;
    end

    if (collide)      ovr_d = 1'b1;
    else if (clr_ovr) ovr_d = 1'b0;

    if (expire)      exp_d = 1'b1;
    else if (launch) exp_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      ovr_q   <= 1'b0;
      exp_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      ovr_q   <= ovr_d;
      exp_q   <= exp_d;
    end
  end

  always_comb begin
    valid   = valid_q;
    data    = data_q;
    overrun = ovr_q;
    expired = exp_q;
  end

endmodule

// File: rtl/codec_cmd_ctrl.sv
module codec_cmd_ctrl #(
  parameter int unsigned IDX_W      = 7,
  parameter int unsigned DAT_W      = 16,
  parameter int unsigned TMO_CYCLES = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  output logic             lnk_req,
  output logic             lnk_rd,
  output logic [IDX_W-1:0] lnk_idx,
  output logic [DAT_W-1:0] lnk_wdata,
  input  logic             lnk_ack,
  input  logic [DAT_W-1:0] lnk_rdata
);

  localparam int unsigned REG_W = 32;
  localparam int unsigned IDX_B = DAT_W;
  localparam int unsigned RD_B  = DAT_W + IDX_W;
  localparam int unsigned VLD_B = RD_B + 1;
  localparam int unsigned BSY_B = RD_B + 2;
  localparam int unsigned OVR_B = RD_B + 3;
  localparam int unsigned EXP_B = RD_B + 4;
  localparam int unsigned PAD_W = REG_W - EXP_B - 1;

  logic launch, collide, clr_ovr;
  logic busy, done_ok, expire;
  logic valid, overrun, expired;
  logic [DAT_W-1:0] data;
  logic unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[REG_W-1:EXP_B], wr_data[BSY_B]};

  ccr_accept u_accept (
    .wr_en       (wr_en),
    .cmd_vld     (wr_data[VLD_B]),
    .cmd_clr_ovr (wr_data[OVR_B]),
    .busy        (busy),
    .launch      (launch),
    .collide     (collide),
    .clr_ovr     (clr_ovr)
  );

  ccr_link_fsm #(
    .IDX_W      (IDX_W),
    .DAT_W      (DAT_W),
    .TMO_CYCLES (TMO_CYCLES)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .cmd_rd    (wr_data[RD_B]),
    .cmd_idx   (wr_data[RD_B-1:IDX_B]),
    .cmd_wdata (wr_data[DAT_W-1:0]),
    .ack       (lnk_ack),
    .busy      (busy),
    .req_rd    (lnk_rd),
    .req_idx   (lnk_idx),
    .req_wdata (lnk_wdata),
    .done_ok   (done_ok),
    .expire    (expire)
  );

  ccr_status #(
    .DAT_W (DAT_W)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .cmd_rd   (wr_data[RD_B]),
    .cmd_data (wr_data[DAT_W-1:0]),
    .collide  (collide),
    .clr_ovr  (clr_ovr),
    .done_ok  (done_ok),
    .done_rd  (lnk_rd),
    .ack_data (lnk_rdata),
    .expire   (expire),
    .valid    (valid),
    .data     (data),
    .overrun  (overrun),
    .expired  (expired)
  );

  always_comb begin
    lnk_req = busy;
    rd_data = {{PAD_W{1'b0}}, expired, overrun, busy, valid, lnk_rd, lnk_idx, data};
  end

endmodule

// File: rtl/codec_cmd_ctrl_chk.sv
module codec_cmd_ctrl_chk #(
  parameter int unsigned IDX_W      = 7,
  parameter int unsigned DAT_W      = 16,
  parameter int unsigned TMO_CYCLES = 2000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic [31:0]      rd_data,
  input logic             lnk_req,
  input logic             lnk_rd,
  input logic [IDX_W-1:0] lnk_idx,
  input logic             lnk_ack
);

  localparam int unsigned RD_B  = DAT_W + IDX_W;
  localparam int unsigned VLD_B = RD_B + 1;
  localparam int unsigned BSY_B = RD_B + 2;
  localparam int unsigned OVR_B = RD_B + 3;
  localparam int unsigned RW    = $clog2(TMO_CYCLES + 1) + 1;

  logic busy, valid;
  logic [RW-1:0] run_q;

  assign busy  = rd_data[BSY_B];
  assign valid = rd_data[VLD_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  assert_launch_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && wr_data[VLD_B]) |=> (busy && lnk_req));

  assert_read_clears_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && wr_data[VLD_B] && wr_data[RD_B]) |=> !valid);

  assert_valid_from_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(lnk_ack && lnk_rd && busy));

  assert_collide_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> ($stable(lnk_idx) && $stable(lnk_rd) && rd_data[OVR_B]));

  assert_no_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && !wr_data[VLD_B]) |=> !lnk_req);

  assert_idle_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en && lnk_ack) |=> $stable(rd_data));

  assert_bounded_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < RW'(TMO_CYCLES)));

endmodule

bind codec_cmd_ctrl codec_cmd_ctrl_chk #(
  .IDX_W      (IDX_W),
  .DAT_W      (DAT_W),
  .TMO_CYCLES (TMO_CYCLES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .lnk_req (lnk_req),
  .lnk_rd  (lnk_rd),
  .lnk_idx (lnk_idx),
  .lnk_ack (lnk_ack)
);

// File: tb/codec_cmd_ctrl_test.sv
`timescale 1ns/1ps
module codec_cmd_ctrl_test;

  localparam int TMO = 24;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        lnk_req, lnk_rd, lnk_ack;
  logic [6:0]  lnk_idx;
  logic [15:0] lnk_wdata, lnk_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // framer model state
  bit          stub_en = 1;
  int          stub_lat = 0;
  int          stub_cnt = 0;
  logic [15:0] stub_rdata = '0;
  bit          force_ack = 0;
  logic [6:0]  cap_idx = '0;
  logic        cap_rd = 0;
  logic [15:0] cap_wdata = '0;

  codec_cmd_ctrl #(.TMO_CYCLES(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .lnk_req(lnk_req), .lnk_rd(lnk_rd),
    .lnk_idx(lnk_idx), .lnk_wdata(lnk_wdata), .lnk_ack(lnk_ack),
    .lnk_rdata(lnk_rdata)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  initial begin
    lnk_ack = 0;
    lnk_rdata = '0;
  end

  always @(posedge clk) begin
    #1;
    if (lnk_ack) begin
      lnk_ack = 0;
      stub_cnt = 0;
    end else if (force_ack) begin
      lnk_ack = 1;
      lnk_rdata = 16'hDEAD;
      force_ack = 0;
    end else if (stub_en && lnk_req) begin
      if (stub_cnt >= stub_lat) begin
        lnk_ack = 1;
        lnk_rdata = stub_rdata;
        cap_idx = lnk_idx;
        cap_rd = lnk_rd;
        cap_wdata = lnk_wdata;
        stub_cnt = 0;
      end else begin
        stub_cnt++;
      end
    end else begin
      stub_cnt = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [31:0] w);
    wr_en = 1;
    wr_data = w;
    @(negedge clk);
    wr_en = 0;
    wr_data = '0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 200 && rd_data[25]; n++) @(negedge clk);
  endtask

  function automatic logic [31:0] cmd(input bit clr, input bit vld, input bit rd,
                                      input logic [6:0] idx, input logic [15:0] d);
    return {4'b0, 1'b0, clr, 1'b0, vld, rd, idx, d};
  endfunction

  // {rd, idx[6:0], data[15:0], latency[3:0], ack data[15:0]}
  localparam logic [43:0] VEC [6] = '{
    {1'b0, 7'h02, 16'h8000, 4'd0, 16'h0000},
    {1'b1, 7'h02, 16'h0000, 4'd3, 16'h1234},
    {1'b0, 7'h7F, 16'hFFFF, 4'd5, 16'h0000},
    {1'b1, 7'h7C, 16'h0000, 4'd1, 16'hABCD},
    {1'b1, 7'h00, 16'h0000, 4'd0, 16'h0000},
    {1'b0, 7'h26, 16'h0F0F, 4'd2, 16'h0000}
  };

  initial begin
    logic [31:0] snap;
    bit exp_valid;
    rst_n = 0;
    wr_en = 0;
    wr_data = '0;
    exp_valid = 0;
    repeat (3) @(negedge clk);
    check("R1 status word", rd_data, 32'h0);
    check("R1 request", {31'b0, lnk_req}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", rd_data, 32'h0);

    // table of transactions
    for (int i = 0; i < 6; i++) begin
      logic rd; logic [6:0] idx; logic [15:0] d, rdat;
      {rd, idx, d} = VEC[i][43:20];
      rdat = VEC[i][15:0];
      stub_lat = int'(VEC[i][19:16]);
      stub_rdata = rdat;
      host_write(cmd(1'b0, 1'b1, rd, idx, d));
      check("R2 busy after launch", {31'b0, rd_data[25]}, 32'h1);
      check("R2 request fields", {23'b0, lnk_req, lnk_rd, lnk_idx},
            {23'b0, 1'b1, rd, idx});
      if (rd) check("R4 valid cleared at launch", {31'b0, rd_data[24]}, 32'h0);
      wait_idle();
      check("R2 framer saw command", {8'b0, cap_rd, cap_idx, cap_wdata}, {8'b0, rd, idx, d});
      if (rd) begin
        exp_valid = 1;
        check("R4 read data and valid", {15'b0, rd_data[25:24], rd_data[15:0]},
              {15'b0, 2'b01, rdat});
      end else begin
        check("R3 write done, valid kept", {15'b0, rd_data[25:24], rd_data[15:0]},
              {15'b0, 1'b0, exp_valid, d});
      end
    end

    // collision while busy
    stub_lat = 4;
    stub_rdata = 16'h4242;
    host_write(cmd(1'b0, 1'b1, 1'b1, 7'h10, 16'h0));
    host_write(cmd(1'b0, 1'b1, 1'b0, 7'h33, 16'h5555));
    check("R5 fields held", {24'b0, lnk_rd, lnk_idx}, {24'b0, 1'b1, 7'h10});
    check("R5 overrun set", {31'b0, rd_data[26]}, 32'h1);
    wait_idle();
    check("R5 original read completes", {15'b0, cap_idx, rd_data[15:0]}, {15'b0, 7'h10, 16'h4242});
    stub_lat = 1;
    host_write(cmd(1'b0, 1'b1, 1'b0, 7'h11, 16'h0001));
    wait_idle();
    check("R6 overrun kept", {31'b0, rd_data[26]}, 32'h1);
    host_write(cmd(1'b1, 1'b1, 1'b0, 7'h12, 16'h0002));
    wait_idle();
    check("R6 overrun cleared", {31'b0, rd_data[26]}, 32'h0);

    // command without launch bit
    snap = rd_data;
    host_write(cmd(1'b0, 1'b0, 1'b1, 7'h44, 16'h7777));
    check("R7 no request", {31'b0, lnk_req}, 32'h0);
    @(negedge clk);
    check("R7 status unchanged", rd_data, snap);

    // stray acknowledge while idle
    snap = rd_data;
    force_ack = 1;
    repeat (3) @(negedge clk);
    check("R9 idle ack ignored", rd_data, snap);

    // unanswered request
    stub_en = 0;
    host_write(cmd(1'b0, 1'b1, 1'b1, 7'h05, 16'h0123));
    repeat (TMO - 1) @(negedge clk);
    check("R8 busy until limit", {31'b0, rd_data[25]}, 32'h1);
    @(negedge clk);
    check("R8 expired", {28'b0, rd_data[27:24]}, {28'b0, 4'b1000});
    check("R8 data kept", {16'b0, rd_data[15:0]}, 32'h0123);
    stub_en = 1;
    stub_lat = 0;
    host_write(cmd(1'b0, 1'b1, 1'b0, 7'h06, 16'h0456));
    check("R8 expired cleared on launch", {31'b0, rd_data[27]}, 32'h0);
    wait_idle();
    check("R3 write after expiry", {16'b0, rd_data[15:0]}, 32'h0456);

    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule